// File: doc/BRIEF.md
# JTAG Serial Output Retiming and Pad Enable

This block sits between the scan registers of a test access port and the three-state output pad that carries serial test data off the chip. It takes the last-bit outputs of the instruction register, the identification register and the one-bit bypass register, all of which shift on the rising edge of the test clock. It also takes the output of a built-in self-test chain that the self-test logic has already registered on the falling edge. The block picks the serial source that belongs to the current shift state and instruction, and drives the pad data together with an active-high enable for the pad buffer.

Every path to the pad passes through exactly one falling-edge stage. Each rising-edge source gets its own falling-edge flop in front of the selection mux. The self-test chain, which is already falling-edge timed, goes to the mux directly. Nothing is registered after the mux. Data leaves the chip half a test-clock period after the scan shift, which keeps the hold margin of the next device in an external daisy chain safe without adding a cycle of latency.

The source choice and the pad enable are also registered on the falling edge, so they change in step with the data. An active-low test reset clears all of this state asynchronously.

Top module: `jtag_tdo_retime`

## Requirements
- R1: While `trst_n` is low, `tdo_oe` and `tdo_data` are 0, and they clear at once when `trst_n` falls, without waiting for a clock edge.
- R2: `tdo_oe` updates only on falling edges of `tck`. After a falling edge at which `shift_ir` or `shift_dr` was high it is 1; otherwise it is 0.
- R3: After a falling edge at which `shift_ir` was high, `tdo_data` carries the instruction-register bit `ir_so`. `shift_ir` takes priority over `shift_dr`.
- R4: After a falling edge at which `shift_dr` was high, `shift_ir` was low and `instr_sel` was 2'b01, `tdo_data` carries the identification bit `idcode_so`.
- R5: After a falling edge at which `instr_sel` was 2'b00 or the unrecognised code 2'b11 with only `shift_dr` high, or at which neither shift flag was high, `tdo_data` carries the bypass bit `bypass_so`.
- R6: A new value presented on `ir_so`, `idcode_so` or `bypass_so` after a rising edge does not reach `tdo_data` before the next falling edge. From that falling edge on, `tdo_data` holds it until the following falling edge.
- R7: After a falling edge at which only `shift_dr` was high with `instr_sel` 2'b10, `tdo_data` follows `bist_so` with no clock stage in between. A change on `bist_so` appears on `tdo_data` within the same half period.
- R8: A change on `shift_ir`, `shift_dr` or `instr_sel` made after a rising edge changes the selected source only at the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| shift_ir | input | 1 | TAP controller is in the instruction shift state |
| shift_dr | input | 1 | TAP controller is in the data shift state |
| instr_sel | input | 2 | Decoded instruction: 00 bypass, 01 identification, 10 self-test chain, 11 unrecognised |
| ir_so | input | 1 | Instruction register serial output, rising-edge timed |
| idcode_so | input | 1 | Identification register serial output, rising-edge timed |
| bypass_so | input | 1 | Bypass register serial output, rising-edge timed |
| bist_so | input | 1 | Self-test chain serial output, already falling-edge timed |
| tdo_data | output | 1 | Serial data to the pad buffer |
| tdo_oe | output | 1 | Pad buffer enable, active high |

## Verification
On every falling edge, the assertions check that the enable follows the shift flags of the previous falling edge, and that the instruction, identification and fallback-bypass paths deliver the bit sampled one falling edge earlier. Three behaviours can only be shown by the bench's scenarios. The first is that a rising-edge source bit stays hidden during the high half of the clock. The second is that the self-test bit arrives with no stage at all. The third is that an asynchronous reset clears the outputs in the middle of a cycle. The bench sweeps every combination of shift flags and instruction code under changing bit patterns to show these.

// File: rtl/jtag_tdo_pkg.sv
package jtag_tdo_pkg;

    localparam int unsigned SEL_W = 2;

    // decoded instruction codes seen on instr_sel
    localparam logic [SEL_W-1:0] CODE_BYPASS = 2'b00;
    localparam logic [SEL_W-1:0] CODE_IDCODE = 2'b01;
    localparam logic [SEL_W-1:0] CODE_BIST   = 2'b10;

    // rising-edge sources, index into the retiming vector
    localparam int unsigned RISE_IR     = 0;
    localparam int unsigned RISE_IDCODE = 1;
    localparam int unsigned RISE_BYPASS = 2;
    localparam int unsigned N_RISE      = 3;

    typedef enum logic [1:0] {
        SRC_BYPASS = 2'd0,
        SRC_IDCODE = 2'd1,
        SRC_BIST   = 2'd2,
        SRC_IR     = 2'd3
    } tdo_src_e;

    typedef struct packed {
        logic ir;
        logic idcode;
        logic bypass;
    } rise_bits_t;

    function automatic tdo_src_e pick_source(
        input logic             sir,
        input logic             sdr,
        input logic [SEL_W-1:0] code
    );
        tdo_src_e s;
        s = SRC_BYPASS;
        if (sir) begin
            s = SRC_IR;
        end else if (sdr) begin
            unique case (code)
                CODE_IDCODE: s = SRC_IDCODE;
                CODE_BIST:   s = SRC_BIST;
                default:     s = SRC_BYPASS;
            endcase
        end
        return s;
    endfunction

    function automatic logic [N_RISE-1:0] pack_rise(input rise_bits_t b);
        logic [N_RISE-1:0] v;
        v[RISE_IR]     = b.ir;
        v[RISE_IDCODE] = b.idcode;
        v[RISE_BYPASS] = b.bypass;
        return v;
    endfunction

endpackage

// File: rtl/tdo_fall_retime.sv
module tdo_fall_retime #(
    parameter int unsigned WIDTH     = 3,
    parameter logic        CLEAR_VAL = 1'b0
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic [WIDTH-1:0] d_rise,
    output logic [WIDTH-1:0] q_fall
);
    // one falling-edge flop per rising-edge source
    for (genvar g = 0; g < WIDTH; g++) begin : g_stage
        always_ff @(negedge tck or negedge trst_n) begin
            if (!trst_n) q_fall[g] <= CLEAR_VAL;
            else         q_fall[g] <= d_rise[g];
        end
    end
endmodule

// File: rtl/tdo_src_select.sv
module tdo_src_select
    import jtag_tdo_pkg::*;
(
    input  logic             tck,
    input  logic             trst_n,
    input  logic             shift_ir,
    input  logic             shift_dr,
    input  logic [SEL_W-1:0] instr_sel,
    output tdo_src_e         src_q
);
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) src_q <= SRC_BYPASS;
        else         src_q <= pick_source(shift_ir, shift_dr, instr_sel);
    end
endmodule

// File: rtl/tdo_pad_enable.sv
module tdo_pad_enable (
    input  logic tck,
    input  logic trst_n,
    input  logic shift_ir,
    input  logic shift_dr,
    output logic oe_q
);
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) oe_q <= 1'b0;
        else         oe_q <= shift_ir | shift_dr;
    end

    assert_oe_on_R2: assert property (@(negedge tck) disable iff (!trst_n)
        (shift_ir || shift_dr) |=> oe_q);
    assert_oe_off_R2: assert property (@(negedge tck) disable iff (!trst_n)
        !(shift_ir || shift_dr) |=> !oe_q);
endmodule

// File: rtl/jtag_tdo_retime.sv
module jtag_tdo_retime
    import jtag_tdo_pkg::*;
#(
    parameter logic CLEAR_VAL = 1'b0
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             shift_ir,
    input  logic             shift_dr,
    input  logic [SEL_W-1:0] instr_sel,
    input  logic             ir_so,
    input  logic             idcode_so,
    input  logic             bypass_so,
    input  logic             bist_so,
    output logic             tdo_data,
    output logic             tdo_oe
);
    rise_bits_t        rise_in;
    logic [N_RISE-1:0] rise_vec;
    logic [N_RISE-1:0] fall_vec;
    tdo_src_e          src_q;

    assign rise_in  = '{ir: ir_so, idcode: idcode_so, bypass: bypass_so};
    assign rise_vec = pack_rise(rise_in);

    tdo_fall_retime #(.WIDTH(N_RISE), .CLEAR_VAL(CLEAR_VAL)) u_retime (
        .tck    (tck),
        .trst_n (trst_n),
        .d_rise (rise_vec),
        .q_fall (fall_vec)
    );

    tdo_src_select u_select (
        .tck       (tck),
        .trst_n    (trst_n),
        .shift_ir  (shift_ir),
        .shift_dr  (shift_dr),
        .instr_sel (instr_sel),
        .src_q     (src_q)
    );

    tdo_pad_enable u_enable (
        .tck      (tck),
        .trst_n   (trst_n),
        .shift_ir (shift_ir),
        .shift_dr (shift_dr),
        .oe_q     (tdo_oe)
    );

    // mux straight to the pad: the self-test bit is already falling-edge timed
    always_comb begin
        unique case (src_q)
            SRC_IR:     tdo_data = fall_vec[RISE_IR];
            SRC_IDCODE: tdo_data = fall_vec[RISE_IDCODE];
            SRC_BIST:   tdo_data = bist_so;
            default:    tdo_data = fall_vec[RISE_BYPASS];
        endcase
    end

    assert_ir_path_R3: assert property (@(negedge tck) disable iff (!trst_n)
        shift_ir |=> (tdo_data == $past(ir_so)));
    assert_idcode_path_R4: assert property (@(negedge tck) disable iff (!trst_n)
        (shift_dr && !shift_ir && instr_sel == CODE_IDCODE)
        |=> (tdo_data == $past(idcode_so)));
    assert_unknown_code_bypass_R5: assert property (@(negedge tck) disable iff (!trst_n)
        (shift_dr && !shift_ir && instr_sel == 2'b11)
        |=> (tdo_data == $past(bypass_so)));
    assert_idle_bypass_R5: assert property (@(negedge tck) disable iff (!trst_n)
        (!shift_dr && !shift_ir) |=> (tdo_data == $past(bypass_so)));
endmodule

// File: tb/jtag_tdo_retime_test.sv
module jtag_tdo_retime_test;
    localparam int PERIOD = 10;

    logic       tck = 1'b0;
    logic       trst_n = 1'b0;
    logic       shift_ir = 1'b0, shift_dr = 1'b0;
    logic [1:0] instr_sel = 2'b00;
    logic       ir_so = 1'b0, idcode_so = 1'b0, bypass_so = 1'b0, bist_so = 1'b0;
    logic       tdo_data, tdo_oe;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // expected state as of the last falling edge
    int   prev_src = 0;   // 0 bypass, 1 idcode, 2 bist, 3 ir
    logic prev_bit = 1'b0;

    always #(PERIOD/2) tck = ~tck;

    jtag_tdo_retime uut (
        .tck(tck), .trst_n(trst_n), .shift_ir(shift_ir), .shift_dr(shift_dr),
        .instr_sel(instr_sel), .ir_so(ir_so), .idcode_so(idcode_so),
        .bypass_so(bypass_so), .bist_so(bist_so),
        .tdo_data(tdo_data), .tdo_oe(tdo_oe)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_src(input logic sir, input logic sdr, input logic [1:0] c);
        if (sir) return 3;
        if (sdr && c == 2'b01) return 1;
        if (sdr && c == 2'b10) return 2;
        return 0;
    endfunction

    // one full test-clock cycle; the rising-edge sources change after the rising edge
    task automatic cycle(input logic sir, input logic sdr, input logic [1:0] c, input int n);
        int   s;
        logic b_ir, b_id, b_by, b_bi;
        b_ir = logic'((n * 3 + 1) % 5 < 2);
        b_id = logic'(((n * 7) >> 1) & 1);
        b_by = logic'(n % 3 == 0);
        b_bi = logic'(((n * 5 + 2) >> 2) & 1);
        @(posedge tck);
        #1;
        shift_ir = sir; shift_dr = sdr; instr_sel = c;
        ir_so = b_ir; idcode_so = b_id; bypass_so = b_by;
        #2;
        // high half: nothing new may show yet (R6, R8)
        if (prev_src != 2) check("R6", tdo_data, prev_bit);
        else               check("R7", tdo_data, bist_so);
        @(negedge tck);
        #1;
        bist_so = b_bi;
        #1;
        s = exp_src(sir, sdr, c);
        check("R2", tdo_oe, sir | sdr);
        case (s)
            3: check("R3", tdo_data, b_ir);
            1: check("R4", tdo_data, b_id);
            2: check("R7", tdo_data, b_bi);
            default: check("R5", tdo_data, b_by);
        endcase
        if (s == 2) begin
            #1;
            bist_so = ~b_bi;
            #0.5;
            check("R7", tdo_data, ~b_bi);
        end
        prev_src = s;
        prev_bit = (s == 3) ? b_ir : (s == 1) ? b_id : (s == 2) ? bist_so : b_by;
    endtask

    initial begin
        int n;
        n = 0;
        #2;
        check("R1", tdo_oe, 1'b0);
        check("R1", tdo_data, 1'b0);
        @(posedge tck);
        @(posedge tck);
        #3;
        trst_n = 1'b1;
        // sweep every shift-flag and instruction combination
        for (int sir = 0; sir < 2; sir++)
            for (int sdr = 0; sdr < 2; sdr++)
                for (int c = 0; c < 4; c++)
                    for (int k = 0; k < 8; k++) begin
                        cycle(logic'(sir), logic'(sdr), 2'(c), n);
                        n++;
                    end
        // select and enable switch only at the falling edge (R8)
        cycle(1'b0, 1'b1, 2'b10, n); n++;
        cycle(1'b1, 1'b0, 2'b00, n); n++;
        cycle(1'b0, 1'b1, 2'b01, n); n++;
        cycle(1'b0, 1'b0, 2'b11, n); n++;
        // asynchronous reset in the middle of a shift (R1)
        cycle(1'b1, 1'b0, 2'b00, n); n++;
        cycle(1'b1, 1'b0, 2'b00, 2);
        @(posedge tck);
        #2;
        trst_n = 1'b0;
        #1;
        check("R1", tdo_oe, 1'b0);
        check("R1", tdo_data, 1'b0);
        @(negedge tck);
        #1;
        check("R1", tdo_oe, 1'b0);
        check("R1", tdo_data, 1'b0);
        @(posedge tck);
        #3;
        trst_n = 1'b1;
        prev_src = 0;
        prev_bit = 1'b0;
        for (int k = 0; k < 6; k++) begin
            cycle(1'b0, 1'b1, 2'(k % 4), n);
            n++;
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(PERIOD * 20000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule